// File: doc/BRIEF.md
# Four-Channel Up-Counting Compare Timer

This block is a general-purpose up-counting timer. A programmable prescaler divides the input clock. The counter runs from zero up to a programmable reload value, then wraps back to zero and raises an update event. Four compare channels watch the counter. Each channel drives one output pin according to a 3-bit compare mode: it can hold, set, clear or toggle the pin on a match, force the pin to a fixed level, or produce an edge-aligned PWM waveform in either polarity.

Software drives the block only through single-cycle register writes. It can program the prescaler, reload value, compare values, channel modes and per-channel pin enables. It can issue a software update command, clear status flags and choose which flags raise the interrupt line. Options include a single-shot mode that stops the counter at its first wrap, preload buffering of the reload and compare values, and a quiet bit that keeps software updates from setting the update flag. The live count, the status flags, the interrupt line and the four pins are brought out as ports.

Top module: `tmr_core`

## Requirements
- R1: While running, the counter advances by one every (P+1) clock cycles, where P is the prescaler value (address 1) that was loaded at the last update event.
- R2: The counter counts 0,1,...,R and then wraps to 0. R is the reload value at address 2. The wrap is an update event that sets status bit 0, so one period lasts (R+1)(P+1) cycles.
- R3: A write of 0 to the reload register is ignored, and the previous reload value stays in force.
- R4: Writing 1 to bit 0 of the event register (address 3) is a software update. It clears the counter and the prescaler, and it loads the prescaler value and the buffered reload and compare values. It sets status bit 0 unless control bit 1 (quiet) is set.
- R5: Writing the status register (address 4) clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R6: The interrupt output is high while any status bit and the matching bit of the enable register (address 5) are both 1. Bit 0 is the update flag, and bit n+1 is the flag of channel n.
- R7: The flag of channel n (status bit n+1) is set on the count step at which the counter takes the compare value at address 8+n.
- R8: The mode field of channel n sits at bits 4n+2..4n of address 6. On a compare match, mode 1 drives the pin high, mode 2 drives it low, mode 3 toggles it, and mode 0 leaves it unchanged.
- R9: Mode 4 holds the pin low and mode 5 holds it high, regardless of the counter.
- R10: Mode 6 drives the pin high while count < compare and low otherwise. Mode 7 is the inverse.
- R11: The pin of channel n is enabled by bit 4n of address 7. A disabled channel drives its pin low.
- R12: When control bit 2 (single shot) is set together with bit 0 (run), the run bit clears by itself at the first counter wrap, and the counter stays at 0.
- R13: With control bit 3 set, a reload write takes effect only at the next update event. With bit 4n+3 of address 6 set, a compare write for channel n also takes effect only at the next update event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| flags | output | 5 | Status flags: update and four compare flags |
| irq | output | 1 | Interrupt request |
| ch_out | output | 4 | Channel output pins |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and four channels. It uses prescaler values 0 to 2 and reload values 1 to 5, which keeps every period to at most 18 cycles. Sweeping all of these combinations puts several wraps, compare matches, toggle edges and PWM edges into each short run. At every cycle the bench compares the count, flags, interrupt and pins against values it computes arithmetically from the cycle index. Separate short sequences cover refused zero reloads, flag clearing, pin enables, single-shot stop and preload timing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    OC_HOLD     = 3'd0,
    OC_SET_HIT  = 3'd1,
    OC_CLR_HIT  = 3'd2,
    OC_TOG_HIT  = 3'd3,
    OC_FORCE_LO = 3'd4,
    OC_FORCE_HI = 3'd5,
    OC_PWM_LOW  = 3'd6,
    OC_PWM_HIGH = 3'd7
  } oc_mode_e;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_PRESC  = 1;
  localparam int ADR_RELOAD = 2;
  localparam int ADR_EVENT  = 3;
  localparam int ADR_STATUS = 4;
  localparam int ADR_IRQEN  = 5;
  localparam int ADR_MODE   = 6;
  localparam int ADR_PINEN  = 7;
  localparam int ADR_CMP0   = 8;

  localparam int CTL_RUN    = 0;
  localparam int CTL_QUIET  = 1;
  localparam int CTL_SHOT   = 2;
  localparam int CTL_ARRBUF = 3;

  // PWM level from the "count below compare" condition
  function automatic logic pwm_level(oc_mode_e m, logic below);
    return (m == OC_PWM_LOW) ? below : !below;
  endfunction

  // Next stored reference level for the registered modes
  function automatic logic next_ref(oc_mode_e m, logic cur, logic hit, logic pwm);
    case (m)
      OC_SET_HIT:  return hit ? 1'b1 : cur;
      OC_CLR_HIT:  return hit ? 1'b0 : cur;
      OC_TOG_HIT:  return hit ? !cur : cur;
      OC_FORCE_LO: return 1'b0;
      OC_FORCE_HI: return 1'b1;
      OC_PWM_LOW,
      OC_PWM_HIGH: return pwm;
      default:     return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         sw_update,
  input  logic         quiet,
  input  logic         single_shot,
  input  logic         arr_buf,
  input  logic [W-1:0] presc_reg,
  input  logic [W-1:0] reload_reg,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_next,
  output logic         tick,
  output logic         uev,
  output logic         uev_flag,
  output logic         stop_req
);

  logic [W-1:0] pre_q, psc_act, arr_act, arr_eff;
  logic         pre_last, wrap, hw_uev;

  assign arr_eff  = arr_buf ? arr_act : reload_reg;
  assign pre_last = (pre_q == psc_act);
  assign tick     = run && pre_last && !sw_update;
  assign wrap     = (cnt_q == arr_eff);
  assign hw_uev   = tick && wrap;
  assign uev      = hw_uev || sw_update;
  assign uev_flag = hw_uev || (sw_update && !quiet);
  assign stop_req = hw_uev && single_shot;

  always_comb begin
    if (sw_update)  cnt_next = '0;
    else if (tick)  cnt_next = wrap ? '0 : cnt_q + 1'b1;
    else            cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      psc_act <= '0;
      arr_act <= '1;
    end else begin
      cnt_q <= cnt_next;
      if (sw_update)  pre_q <= '0;
      else if (run)   pre_q <= pre_last ? '0 : pre_q + 1'b1;
      if (uev) begin
        psc_act <= presc_reg;
        arr_act <= reload_reg;
      end
    end
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == arr_eff) |=> (cnt_q == '0));

  // R1
  presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_update && pre_q != psc_act) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  oc_mode_e     mode,
  input  logic         cmp_buf,
  input  logic         pin_en,
  input  logic [W-1:0] cmp_reg,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cnt_next,
  input  logic         tick,
  input  logic         uev,
  output logic         hit,
  output logic         pin
);

  logic [W-1:0] cmp_act, cmp_eff;
  logic         ref_q, below, pwm, level;

  assign cmp_eff = cmp_buf ? cmp_act : cmp_reg;
  assign hit     = tick && (cnt_next == cmp_eff);
  assign below   = (cnt_q < cmp_eff);
  assign pwm     = pwm_level(mode, below);

  always_comb begin
    case (mode)
      OC_FORCE_LO:              level = 1'b0;
      OC_FORCE_HI:              level = 1'b1;
      OC_PWM_LOW, OC_PWM_HIGH:  level = pwm;
      default:                  level = ref_q;
    endcase
  end

  assign pin = pin_en && level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act <= '0;
      ref_q   <= 1'b0;
    end else begin
      if (uev) cmp_act <= cmp_reg;
      ref_q <= next_ref(mode, ref_q, hit, pwm);
    end
  end

  // R8
  toggle_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == OC_TOG_HIT && $stable(mode)) |=> (ref_q != $past(ref_q)));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   count,
  output logic [NCH:0]   flags,
  output logic           irq,
  output logic [NCH-1:0] ch_out
);

  localparam int NFL = NCH + 1;

  logic           run_q, quiet_q, shot_q, arrbuf_q;
  logic [W-1:0]   presc_q, reload_q;
  logic [NFL-1:0] flags_q, irqen_q, set_vec;
  logic [NCH-1:0] hit_vec;
  logic [W-1:0]   cnt_q, cnt_next;
  logic           tick, uev, uev_flag, stop_req, sw_update;
  logic           we_ctrl, we_status;

  assign we_ctrl   = wr_en && (wr_addr == AW'(ADR_CTRL));
  assign we_status = wr_en && (wr_addr == AW'(ADR_STATUS));
  assign sw_update = wr_en && (wr_addr == AW'(ADR_EVENT)) && wr_data[0];
  assign set_vec   = {hit_vec, uev_flag};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      quiet_q  <= 1'b0;
      shot_q   <= 1'b0;
      arrbuf_q <= 1'b0;
      presc_q  <= '0;
      reload_q <= '1;
      irqen_q  <= '0;
      flags_q  <= '0;
    end else begin
      if (we_ctrl) begin
        run_q    <= wr_data[CTL_RUN];
        quiet_q  <= wr_data[CTL_QUIET];
        shot_q   <= wr_data[CTL_SHOT];
        arrbuf_q <= wr_data[CTL_ARRBUF];
      end else if (stop_req) begin
        run_q <= 1'b0;
      end
      if (wr_en && wr_addr == AW'(ADR_PRESC)) presc_q <= wr_data;
      if (wr_en && wr_addr == AW'(ADR_RELOAD) && wr_data != '0) reload_q <= wr_data;
      if (wr_en && wr_addr == AW'(ADR_IRQEN)) irqen_q <= wr_data[NFL-1:0];
      flags_q <= (we_status ? (flags_q & wr_data[NFL-1:0]) : flags_q) | set_vec;
    end
  end

  tmr_timebase #(.W(W)) u_timebase (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sw_update(sw_update),
    .quiet(quiet_q), .single_shot(shot_q), .arr_buf(arrbuf_q),
    .presc_reg(presc_q), .reload_reg(reload_q),
    .cnt_q(cnt_q), .cnt_next(cnt_next), .tick(tick), .uev(uev),
    .uev_flag(uev_flag), .stop_req(stop_req)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] cmp_q;
    oc_mode_e     mode_q;
    logic         cbuf_q, en_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q  <= '0;
        mode_q <= OC_HOLD;
        cbuf_q <= 1'b0;
        en_q   <= 1'b0;
      end else begin
        if (wr_en && wr_addr == AW'(ADR_CMP0 + i)) cmp_q <= wr_data;
        if (wr_en && wr_addr == AW'(ADR_MODE)) begin
          mode_q <= oc_mode_e'(wr_data[4*i +: 3]);
          cbuf_q <= wr_data[4*i+3];
        end
        if (wr_en && wr_addr == AW'(ADR_PINEN)) en_q <= wr_data[4*i];
      end
    end

    tmr_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .cmp_buf(cbuf_q),
      .pin_en(en_q), .cmp_reg(cmp_q), .cnt_q(cnt_q), .cnt_next(cnt_next),
      .tick(tick), .uev(uev), .hit(hit_vec[i]), .pin(ch_out[i])
    );
  end

  assign count = cnt_q;
  assign flags = flags_q;
  assign irq   = |(flags_q & irqen_q);

  // R3
  zero_reload_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ADR_RELOAD) && wr_data == '0) |=> $stable(reload_q));

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_status && !wr_data[0] && !uev_flag) |=> !flags_q[0]);

  // R4
  quiet_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_update && quiet_q && !flags_q[0] && !we_ctrl) |=> !flags_q[0]);

  // R12
  single_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !we_ctrl) |=> !run_q);

endmodule

// File: tb/tmr_core_bench.sv
module tmr_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [4:0]  flags;
  logic        irq;
  logic [3:0]  ch_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_core u_tmr_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .flags(flags), .irq(irq), .ch_out(ch_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Stopped, quiet; program prescaler/reload/compares, clear flags, software update
  task automatic setup(input int p, input int r, input int c, input int ctl);
    wr(0, ctl);
    wr(1, p);
    wr(2, r);
    for (int i = 0; i < 4; i++) wr(8 + i, c);
    wr(4, 0);
    wr(3, 1);
  endtask

  task automatic sweep_one(input int p, input int r);
    int c, per, first, ce, ntog;
    c = (r + 1) / 2;
    per = (r + 1) * (p + 1);
    first = c * (p + 1);
    setup(p, r, c, 2);
    wr(5, 1);
    wr(7, 16'h1111);
    wr(6, 16'h5476);
    chk("R9", ch_out[2], 0);
    chk("R9", ch_out[3], 1);
    wr(6, 16'h2376);
    chk("R4", flags, 0);
    chk("R4", count, 0);
    wr(0, 3);
    for (int k = 1; k <= 2 * per + 2; k++) begin
      step();
      ce = (k / (p + 1)) % (r + 1);
      ntog = (k >= first) ? 1 + (k - first) / per : 0;
      chk("R1", count, ce);
      chk("R2", flags[0], (k >= per) ? 1 : 0);
      chk("R7", flags[1], (k >= first) ? 1 : 0);
      chk("R6", irq, (k >= per) ? 1 : 0);
      chk("R10", ch_out[0], (ce < c) ? 1 : 0);
      chk("R10", ch_out[1], (ce < c) ? 0 : 1);
      chk("R8", ch_out[2], ntog % 2);
      chk("R8", ch_out[3], (k < first) ? 1 : 0);
    end
    wr(0, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R2", count, 0);
    chk("R5", flags, 0);
    chk("R6", irq, 0);
    chk("R11", ch_out, 0);

    // Near-exhaustive sweep of small prescaler/reload pairs
    for (int p = 0; p <= 2; p++)
      for (int r = 1; r <= 5; r++)
        sweep_one(p, r);

    // R5 / R6: flags 0 and 1 are set from the last sweep
    chk("R5", flags[1:0], 3);
    wr(4, 16'hFFFE);
    chk("R5", flags[0], 0);
    chk("R5", flags[1], 1);
    chk("R6", irq, 0);
    wr(5, 2);
    chk("R6", irq, 1);
    wr(4, 0);
    chk("R5", flags, 0);
    chk("R6", irq, 0);

    // R4: software update without quiet sets the update flag
    wr(0, 0);
    wr(3, 1);
    chk("R4", flags[0], 1);
    chk("R4", count, 0);

    // R11: pin enables with all channels forced high
    wr(6, 16'h5555);
    wr(7, 0);
    chk("R11", ch_out, 0);
    wr(7, 16'h1000);
    chk("R11", ch_out, 8);
    wr(7, 16'h1111);
    chk("R11", ch_out, 15);

    // R3: zero reload refused, period stays 5
    setup(0, 4, 1, 2);
    wr(2, 0);
    wr(0, 3);
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R3", count, k % 5);
    end
    wr(0, 2);

    // R12: single shot stops at first wrap
    setup(0, 3, 1, 2);
    wr(0, 7);
    for (int k = 1; k <= 8; k++) begin
      step();
      chk("R12", count, (k < 4) ? k : 0);
    end
    chk("R12", flags[0], 1);

    // R13: buffered reload takes effect at the wrap
    setup(0, 3, 1, 16'hA);
    wr(2, 1);
    wr(0, 16'hB);
    for (int k = 1; k <= 8; k++) begin
      step();
      chk("R13", count, (k <= 4) ? (k % 4) : ((k - 4) % 2));
    end
    wr(0, 16'hA);

    // R13: buffered compare value on channel 0 (PWM mode 6)
    wr(8, 2);
    wr(7, 1);
    wr(6, 16'h000E);
    wr(3, 1);
    chk("R13", count, 0);
    chk("R13", ch_out[0], 1);
    wr(8, 0);
    chk("R13", ch_out[0], 1);
    wr(3, 1);
    chk("R13", ch_out[0], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule